// File: doc/BRIEF.md
# Compare-Match Timer Channel

One 16-bit counting channel intended to sit beside its siblings in a multi-channel timer unit. Software programs it through a small byte-addressed register window: a control byte picks where the counting ticks come from (an internal divider of the peripheral clock or edges of an external tick line), which compare register (if any) resets the count, and which tick edge is used. Four compare registers are watched against the counter. Every equality on a counting tick raises a sticky status flag, and two of the compare registers also steer an output pin that can be cleared, set or toggled.

The counter moves only while the run bit for this channel is high. That bit belongs to a start register shared by the whole timer unit, so it arrives here as an input. When a compare register is chosen as the reset source, the channel becomes a periodic timer with a period of that register's value plus one tick. Status flags need a two-step clear: software reads the status byte, then writes a 0 to the flag. A single interrupt line combines the enabled flags.

Top module: `tmr_channel`

## Requirements
- R1: Prescale code in control bits [2:0] of 0, 1, 2 or 3 gives one tick every 1, 4, 16 or 64 clocks while `run_i` is high. The divider restarts when `run_i` is low, so the first tick comes on the 1st, 4th, 16th or 64th clock with run high. The counter holds its value while `run_i` is low.
- R2: Prescale codes 4 to 7 count edges of `ext_tick_i`, chosen by control bits [4:3]: 0 rising, 1 falling, 2 or 3 both. Each edge counts once, on the first clock that samples the new level.
- R3: Control bits [7:5] choose the count reset. Code 1 uses compare A, 2 uses B, 5 uses C and 6 uses D: a tick that finds the counter equal to that register loads 0, so the period is value+1 ticks. Code 3 loads 0 on any clock where `sync_clr_i` is high. Codes 0, 4 and 7 let the counter run free, and with them `sync_clr_i` has no effect.
- R4: A tick on which the counter equals compare register A, B, C or D sets status bit 0, 1, 2 or 3.
- R5: A tick that increments the counter from 0xFFFF to 0 sets status bit 4. A reset to 0 caused by the compare match does not set it.
- R6: A status flag clears only when the status byte was read while that flag was 1 and a later status write holds 0 in that bit. Writing 0 with no such read, or writing 1, leaves the flag set.
- R7: If hardware sets a flag in the same cycle that a valid clearing write hits it, the flag stays set.
- R8: `irq_o` is high exactly when some status bit 4..0 is set and the matching bit of the interrupt-enable byte (offset 4) is 1.
- R9: The I/O control byte (offset 2) holds one nibble per pin: low nibble for pin A, high nibble for pin B. Writing code 1, 2 or 3 drives the pin to 0, and code 5, 6 or 7 drives it to 1. On a later match of that pin's compare register, codes x1, x2 and x3 clear, set or toggle the pin. Codes 0, 4 and 8 to 15 keep the pin as it is.
- R10: A write to the counter (offset 6) loads the written value at that clock edge, overriding any tick or clear in the same cycle.
- R11: Registers read back at these byte offsets: control 0, mode 1 (7 bits), I/O control 2, interrupt enable 4 (6 bits), status 5, counter 6, compare A/B/C/D at 8/10/12/14. After reset all read 0, except status, which reads 0x80 (bit 7 is a constant up-count indication; bits 6 and 5 read 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | This channel's bit of the shared start register |
| ext_tick_i | input | 1 | External tick line, synchronous to clk |
| sync_clr_i | input | 1 | Synchronous count reset from a sibling channel |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms status clearing) |
| addr_i | input | 4 | Byte offset in the register window |
| wdata_i | input | 16 | Write data; byte registers use bits [7:0] |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| pin_a_o | output | 1 | Compare output pin A |
| pin_b_o | output | 1 | Compare output pin B |
| irq_o | output | 1 | Combined enabled interrupt |

## Verification
The assertions cover the local rules on every cycle. A counter write always lands, and a stopped counter never moves. A selected-register match always resets to 0, and wrapping from 0xFFFF always reaches 0 with the overflow flag raised. A flag never drops without a status write, and a hardware set beats a simultaneous clear. A pin moves only on a write or a match, and a divide-by-4 tick is never followed directly by another. Only the directed scenarios can show the rest: the real periods for each reset source and prescale, the edge counts on the external line, the read-then-write order of the flag clear, the start levels and actions on the pins, the interrupt masking, and the register readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // byte offsets inside the channel window
   localparam int OFS_CTL  = 0;
   localparam int OFS_MODE = 1;
   localparam int OFS_IOC  = 2;
   localparam int OFS_IEN  = 4;
   localparam int OFS_STAT = 5;
   localparam int OFS_CNT  = 6;
   localparam int OFS_CMP0 = 8;   // compare i lives at OFS_CMP0 + 2*i

   localparam int NUM_CMP  = 4;
   localparam int NUM_PIN  = 2;
   localparam int NUM_FLAG = NUM_CMP + 1;  // compares plus overflow

   typedef enum logic [2:0] {
      CLR_NONE  = 3'd0,
      CLR_CMP_A = 3'd1,
      CLR_CMP_B = 3'd2,
      CLR_SYNC  = 3'd3,
      CLR_CMP_C = 3'd5,
      CLR_CMP_D = 3'd6
   } clr_src_e;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_sel_e;

   // codes 1..3 and 5..7 drive the pin; others leave it alone
   function automatic logic pin_code_active(input logic [3:0] code);
      return (code[3] == 1'b0) && (code[1:0] != 2'b00);
   endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_pkg::*;
#(
   parameter int PRESC_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] presc_sel,
   input  logic [1:0] edge_sel,
   input  logic       ext_tick,
   output logic       tick
);

   localparam int NUM_INT_DIV = 4;
   localparam int MIN_W       = 2 * (NUM_INT_DIV - 1);

   if (PRESC_W < MIN_W) begin : g_bad_presc
      $error("tmr_tick_gen: PRESC_W too narrow for divide by 64");
   end

   logic [PRESC_W-1:0] div_q;
   logic [PRESC_W-1:0] div_mask;
   logic               ext_q;
   logic               int_hit;
   logic               ext_hit;
   logic               rise;
   logic               fall;

   always_comb begin
      div_mask = '0;
      for (int b = 0; b < PRESC_W; b++) begin
         if (b < 2 * int'(presc_sel[1:0])) div_mask[b] = 1'b1;
      end
   end

   assign int_hit = ((div_q & div_mask) == div_mask);
   assign rise    = ext_tick & ~ext_q;
   assign fall    = ~ext_tick & ext_q;

   always_comb begin
      case (edge_sel_e'(edge_sel))
         EDGE_RISE: ext_hit = rise;
         EDGE_FALL: ext_hit = fall;
         default:   ext_hit = rise | fall;
      endcase
   end

   assign tick = run & (presc_sel[2] ? ext_hit : int_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         ext_q <= 1'b0;
      end else begin
         ext_q <= ext_tick;
         div_q <= run ? div_q + 1'b1 : '0;
      end
   end

   // R1: a divide-by-4 tick is never directly followed by another
   a_r1_div4_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && presc_sel == 3'd1) |=> (!tick || presc_sel != 3'd1));

endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
   import tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ioc_wr,
   input  logic [3:0] wr_code,
   input  logic [3:0] act_code,
   input  logic       match,
   output logic       pin
);

   logic pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (ioc_wr) begin
         if (pin_code_active(wr_code)) pin_q <= wr_code[2];
      end else if (match && pin_code_active(act_code)) begin
         case (act_code[1:0])
            2'd1:    pin_q <= 1'b0;
            2'd2:    pin_q <= 1'b1;
            default: pin_q <= ~pin_q;
         endcase
      end
   end

   assign pin = pin_q;

   // R9: with neither a control write nor a match the pin keeps its level
   a_r9_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ioc_wr && !match) |=> $stable(pin));

endmodule

// File: rtl/tmr_status.sv
module tmr_status
   import tmr_pkg::*;
#(
   parameter int NF = NUM_FLAG
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic          rd_stat,
   input  logic          wr_stat,
   input  logic [NF-1:0] wbits,
   output logic [NF-1:0] flags
);

   logic [NF-1:0] flag_q;
   logic [NF-1:0] armed_q;
   logic [NF-1:0] clr;

   assign clr = {NF{wr_stat}} & armed_q & ~wbits & flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q  <= '0;
         armed_q <= '0;
      end else begin
         flag_q  <= (flag_q & ~clr) | set;
         armed_q <= (rd_stat ? (armed_q | flag_q) : armed_q) & ~clr;
      end
   end

   assign flags = flag_q;

   // R7: a hardware set always lands, whatever software writes
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((flags & $past(set)) == $past(set)));

   // R6: no flag drops without a status write
   a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stat) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int PRESC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              ext_tick_i,
   input  logic              sync_clr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              pin_a_o,
   output logic              pin_b_o,
   output logic              irq_o
);

   localparam int MODE_W = 7;
   localparam int IEN_W  = 6;
   localparam int TOP_OFS = OFS_CMP0 + 2 * (NUM_CMP - 1);

   if (DATA_W < CNT_W) begin : g_bad_data
      $error("tmr_channel: DATA_W must hold the counter");
   end
   if (DATA_W < 8) begin : g_bad_byte
      $error("tmr_channel: DATA_W must hold a byte register");
   end
   if ((1 << ADDR_W) <= TOP_OFS) begin : g_bad_addr
      $error("tmr_channel: ADDR_W cannot reach the last compare register");
   end

   logic [7:0]        ctl_q;
   logic [MODE_W-1:0] mode_q;
   logic [7:0]        ioc_q;
   logic [IEN_W-1:0]  ien_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cmp_q [NUM_CMP];
   logic [NUM_CMP-1:0] match;
   logic [NUM_FLAG-1:0] flag_set;
   logic [NUM_FLAG-1:0] flags;
   logic              tick;
   logic              clr_hit;
   logic              sync_hit;
   logic              cnt_wr;
   logic              ovf_set;
   logic              ioc_wr;
   logic              stat_wr;
   logic              stat_rd;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign cnt_wr  = wr_en_i && hit(addr_i, OFS_CNT);
   assign ioc_wr  = wr_en_i && hit(addr_i, OFS_IOC);
   assign stat_wr = wr_en_i && hit(addr_i, OFS_STAT);
   assign stat_rd = rd_en_i && hit(addr_i, OFS_STAT);

   // byte-wide configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         mode_q <= '0;
         ioc_q  <= '0;
         ien_q  <= '0;
      end else if (wr_en_i) begin
         if (hit(addr_i, OFS_CTL))  ctl_q  <= wdata_i[7:0];
         if (hit(addr_i, OFS_MODE)) mode_q <= wdata_i[MODE_W-1:0];
         if (ioc_wr)                ioc_q  <= wdata_i[7:0];
         if (hit(addr_i, OFS_IEN))  ien_q  <= wdata_i[IEN_W-1:0];
      end
   end

   // compare registers and their equality detectors
   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n) cmp_q[i] <= '0;
         else if (wr_en_i && hit(addr_i, OFS_CMP0 + 2 * i))
            cmp_q[i] <= wdata_i[CNT_W-1:0];
      end
      assign match[i] = tick && (cnt_q == cmp_q[i]);
   end

   tmr_tick_gen #(.PRESC_W(PRESC_W)) i_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_i),
      .presc_sel (ctl_q[2:0]),
      .edge_sel  (ctl_q[4:3]),
      .ext_tick  (ext_tick_i),
      .tick      (tick)
   );

   always_comb begin
      case (clr_src_e'(ctl_q[7:5]))
         CLR_CMP_A: clr_hit = match[0];
         CLR_CMP_B: clr_hit = match[1];
         CLR_CMP_C: clr_hit = match[2];
         CLR_CMP_D: clr_hit = match[3];
         default:   clr_hit = 1'b0;
      endcase
   end

   assign sync_hit = (clr_src_e'(ctl_q[7:5]) == CLR_SYNC) && sync_clr_i;
   assign ovf_set  = tick && !clr_hit && !cnt_wr && !sync_hit && (&cnt_q);
   assign flag_set = {ovf_set, match};

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (cnt_wr)   cnt_q <= wdata_i[CNT_W-1:0];
      else if (sync_hit) cnt_q <= '0;
      else if (tick)     cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
   end

   tmr_status #(.NF(NUM_FLAG)) i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (flag_set),
      .rd_stat (stat_rd),
      .wr_stat (stat_wr),
      .wbits   (wdata_i[NUM_FLAG-1:0]),
      .flags   (flags)
   );

   logic [NUM_PIN-1:0] pins;
   for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      tmr_pin_ctrl i_pin (
         .clk      (clk),
         .rst_n    (rst_n),
         .ioc_wr   (ioc_wr),
         .wr_code  (wdata_i[4*p +: 4]),
         .act_code (ioc_q[4*p +: 4]),
         .match    (match[p]),
         .pin      (pins[p])
      );
   end
   assign pin_a_o = pins[0];
   assign pin_b_o = pins[1];

   assign irq_o = |(flags & ien_q[NUM_FLAG-1:0]);

   always_comb begin
      rdata_o = '0;
      if (hit(addr_i, OFS_CTL))  rdata_o[7:0] = ctl_q;
      if (hit(addr_i, OFS_MODE)) rdata_o[MODE_W-1:0] = mode_q;
      if (hit(addr_i, OFS_IOC))  rdata_o[7:0] = ioc_q;
      if (hit(addr_i, OFS_IEN))  rdata_o[IEN_W-1:0] = ien_q;
      if (hit(addr_i, OFS_STAT)) rdata_o[7:0] = {1'b1, 2'b00, flags};
      if (hit(addr_i, OFS_CNT))  rdata_o[CNT_W-1:0] = cnt_q;
      for (int i = 0; i < NUM_CMP; i++) begin
         if (hit(addr_i, OFS_CMP0 + 2 * i)) rdata_o[CNT_W-1:0] = cmp_q[i];
      end
   end

   // R10: a counter write always lands
   a_r10_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));

   // R3: a match on the chosen reset register brings the count to zero
   a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !cnt_wr) |=> (cnt_q == '0));

   // R1: a stopped counter does not move
   a_r1_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !cnt_wr && !sync_hit) |=> $stable(cnt_q));

   // R5: incrementing past the top wraps to zero and raises overflow
   a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (&cnt_q) && !clr_hit && !cnt_wr && !sync_hit)
         |=> (cnt_q == '0 && flags[NUM_CMP]));

endmodule

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        ext = 1'b0;
   logic        sclr = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        pin_a, pin_b, irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [3:0] A_CTL = 0, A_MODE = 1, A_IOC = 2, A_IEN = 4,
                          A_STAT = 5, A_CNT = 6, A_GA = 8, A_GB = 10,
                          A_GC = 12, A_GD = 14;

   always #2.5 clk = ~clk;

   tmr_channel i_tmr_channel (
      .clk(clk), .rst_n(rst_n), .run_i(run), .ext_tick_i(ext),
      .sync_clr_i(sclr), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .pin_a_o(pin_a), .pin_b_o(pin_b),
      .irq_o(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // every bus task starts and ends at a falling edge and spans one rising edge
   task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic run_for(input int n);
      run = 1'b1;
      repeat (n) @(negedge clk);
      run = 1'b0;
   endtask

   task automatic clear_flags();
      logic [15:0] d;
      bus_rd(A_STAT, d);
      bus_wr(A_STAT, 16'h0000);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      bus_rd(A_CTL, d);  check("R11", "reset control", d, 16'h0000);
      bus_rd(A_STAT, d); check("R11", "reset status", d, 16'h0080);
      bus_rd(A_CNT, d);  check("R11", "reset counter", d, 16'h0000);
      check("R8", "reset irq", {15'd0, irq}, 16'd0);
      check("R9", "reset pins", {14'd0, pin_b, pin_a}, 16'd0);
   endtask

   task automatic t_periodic_and_flag_clear();
      logic [15:0] d;
      bus_wr(A_GA, 16'd4); bus_wr(A_GB, 16'h0100);
      bus_wr(A_GC, 16'h0200); bus_wr(A_GD, 16'h0300);
      bus_wr(A_IEN, 16'h0001);
      bus_wr(A_CTL, 16'h0020);  // reset on compare A, divide by 1
      run_for(7);
      check("R8", "irq after match A", {15'd0, irq}, 16'd1);
      bus_rd(A_CNT, d); check("R3", "count after 7 ticks, period 5", d, 16'd2);
      bus_wr(A_STAT, 16'h0000);  // no prior read: must not clear
      check("R6", "unarmed zero write keeps flag", {15'd0, irq}, 16'd1);
      bus_rd(A_STAT, d); check("R4", "flag A set", d, 16'h0081);
      bus_wr(A_STAT, 16'h00FF);
      check("R6", "writing one keeps flag", {15'd0, irq}, 16'd1);
      bus_wr(A_STAT, 16'h00FE);
      check("R6", "armed zero write clears", {15'd0, irq}, 16'd0);
      bus_rd(A_STAT, d); check("R6", "status after clear", d, 16'h0080);
   endtask

   task automatic t_prescale();
      logic [15:0] d;
      bus_wr(A_CTL, 16'h0001); bus_wr(A_CNT, 16'd0);
      run_for(12);
      bus_rd(A_CNT, d); check("R1", "divide by 4 over 12 clocks", d, 16'd3);
      repeat (10) @(negedge clk);
      bus_rd(A_CNT, d); check("R1", "hold while stopped", d, 16'd3);
      bus_wr(A_CTL, 16'h0002); bus_wr(A_CNT, 16'd0);
      run_for(40);
      bus_rd(A_CNT, d); check("R1", "divide by 16 over 40 clocks", d, 16'd2);
      bus_wr(A_CTL, 16'h0003); bus_wr(A_CNT, 16'd0);
      run_for(130);
      bus_rd(A_CNT, d); check("R1", "divide by 64 over 130 clocks", d, 16'd2);
   endtask

   task automatic ext_pulses();
      run = 1'b1;
      for (int k = 0; k < 3; k++) begin
         ext = 1'b1; repeat (2) @(negedge clk);
         ext = 1'b0; repeat (2) @(negedge clk);
      end
      run = 1'b0;
   endtask

   task automatic t_ext_edges();
      logic [15:0] d;
      bus_wr(A_CTL, 16'h0004); bus_wr(A_CNT, 16'd0);
      ext_pulses();
      bus_rd(A_CNT, d); check("R2", "rising edges", d, 16'd3);
      bus_wr(A_CTL, 16'h000C); bus_wr(A_CNT, 16'd0);
      ext_pulses();
      bus_rd(A_CNT, d); check("R2", "falling edges", d, 16'd3);
      bus_wr(A_CTL, 16'h0014); bus_wr(A_CNT, 16'd0);
      ext_pulses();
      bus_rd(A_CNT, d); check("R2", "both edges", d, 16'd6);
      clear_flags();
   endtask

   task automatic t_clear_sources();
      logic [15:0] d;
      // compare B, value 3: period 4
      clear_flags(); bus_wr(A_GB, 16'd3); bus_wr(A_CTL, 16'h0040); bus_wr(A_CNT, 16'd0);
      run_for(9);
      bus_rd(A_CNT, d);  check("R3", "reset on B", d, 16'd1);
      bus_rd(A_STAT, d); check("R4", "flag B", d, 16'h0082);
      bus_wr(A_GB, 16'h0100);
      // compare C, value 6: period 7; A at 4 also matches
      clear_flags(); bus_wr(A_GC, 16'd6); bus_wr(A_CTL, 16'h00A0); bus_wr(A_CNT, 16'd0);
      run_for(10);
      bus_rd(A_CNT, d);  check("R3", "reset on C", d, 16'd3);
      bus_rd(A_STAT, d); check("R4", "flags A and C", d, 16'h0085);
      bus_wr(A_GC, 16'h0200);
      // compare D, value 2: period 3
      clear_flags(); bus_wr(A_GD, 16'd2); bus_wr(A_CTL, 16'h00C0); bus_wr(A_CNT, 16'd0);
      run_for(5);
      bus_rd(A_CNT, d);  check("R3", "reset on D", d, 16'd2);
      bus_rd(A_STAT, d); check("R4", "flag D", d, 16'h0088);
      bus_wr(A_GD, 16'h0300);
      clear_flags();
   endtask

   task automatic t_sync_clear();
      logic [15:0] d;
      bus_wr(A_CTL, 16'h0060); bus_wr(A_CNT, 16'd0);
      run_for(5);
      bus_rd(A_CNT, d); check("R3", "sync mode ignores compare A", d, 16'd5);
      sclr = 1'b1; @(negedge clk); sclr = 1'b0;
      bus_rd(A_CNT, d); check("R3", "sync reset", d, 16'd0);
      bus_wr(A_CTL, 16'h0000); bus_wr(A_CNT, 16'd5);
      sclr = 1'b1; @(negedge clk); sclr = 1'b0;
      bus_rd(A_CNT, d); check("R3", "sync line ignored in free run", d, 16'd5);
      clear_flags();
   endtask

   task automatic t_overflow_irq();
      logic [15:0] d;
      clear_flags();
      bus_wr(A_IEN, 16'h0001); bus_wr(A_CTL, 16'h0000); bus_wr(A_CNT, 16'hFFFE);
      run_for(3);
      bus_rd(A_CNT, d); check("R5", "count after wrap", d, 16'd1);
      check("R8", "overflow masked", {15'd0, irq}, 16'd0);
      bus_rd(A_STAT, d); check("R5", "overflow flag", d, 16'h0090);
      bus_wr(A_IEN, 16'h0010);
      check("R8", "overflow enabled", {15'd0, irq}, 16'd1);
      clear_flags();
      bus_wr(A_IEN, 16'h0001);
   endtask

   task automatic t_set_wins();
      logic [15:0] d;
      bus_wr(A_CTL, 16'h0020); bus_wr(A_CNT, 16'd0); clear_flags();
      run = 1'b1;
      repeat (5) @(negedge clk);        // match A on the 5th edge
      bus_rd(A_STAT, d);                 // arms flag A (6th edge)
      check("R4", "flag A before race", d, 16'h0081);
      repeat (3) @(negedge clk);         // edges 7..9
      bus_wr(A_STAT, 16'h0000);          // edge 10: new match A at the same time
      run = 1'b0;
      check("R7", "irq kept by simultaneous set", {15'd0, irq}, 16'd1);
      bus_rd(A_STAT, d); check("R7", "flag A kept", d, 16'h0081);
      clear_flags();
   endtask

   task automatic t_pins();
      logic [15:0] d;
      bus_wr(A_GB, 16'd2); bus_wr(A_CTL, 16'h0020); bus_wr(A_CNT, 16'd0);
      bus_wr(A_IOC, 16'h0053);   // A: start 0, toggle; B: start 1, clear
      check("R9", "start levels 0/1", {14'd0, pin_b, pin_a}, 16'b10);
      run_for(5);
      check("R9", "A toggled, B cleared", {14'd0, pin_b, pin_a}, 16'b01);
      run_for(5);
      check("R9", "A toggled back, B stays", {14'd0, pin_b, pin_a}, 16'b00);
      bus_wr(A_CNT, 16'd0);
      bus_wr(A_IOC, 16'h0062);   // A: start 0, set; B: start 1, set
      check("R9", "start levels again", {14'd0, pin_b, pin_a}, 16'b10);
      run_for(5);
      check("R9", "set actions", {14'd0, pin_b, pin_a}, 16'b11);
      bus_wr(A_IOC, 16'h0000);
      run_for(5);
      check("R9", "retain code keeps pins", {14'd0, pin_b, pin_a}, 16'b11);
      bus_wr(A_GB, 16'h0100);
      clear_flags();
   endtask

   task automatic t_load_readback();
      logic [15:0] d;
      bus_wr(A_CTL, 16'h0000); bus_wr(A_CNT, 16'd0);
      run = 1'b1;
      bus_wr(A_CNT, 16'h1234);   // tick in the same cycle loses
      run = 1'b0;
      bus_rd(A_CNT, d); check("R10", "write beats tick", d, 16'h1234);
      bus_wr(A_MODE, 16'h0045); bus_rd(A_MODE, d); check("R11", "mode", d, 16'h0045);
      bus_wr(A_IEN, 16'h003F);  bus_rd(A_IEN, d);  check("R11", "enable", d, 16'h003F);
      bus_wr(A_IOC, 16'h00A7);  bus_rd(A_IOC, d);  check("R11", "io control", d, 16'h00A7);
      bus_rd(A_GD, d); check("R11", "compare D", d, 16'h0300);
      bus_rd(A_CTL, d); check("R11", "control", d, 16'h0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_periodic_and_flag_clear();
      t_prescale();
      t_ext_edges();
      t_clear_sources();
      t_sync_clear();
      t_overflow_irq();
      t_set_wins();
      t_pins();
      t_load_readback();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule